// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Per-Line Interrupt Detection

This block is a general-purpose I/O peripheral with sixteen lines, reached over a simple 32-bit register bus that has a write strobe, a byte address and a registered read path. Software sets the value each line drives and whether the line drives at all. It reads back the synchronised pin levels. For each line it also picks a trigger style, and the block uses that style to decide when the line raises an interrupt.

Each pin passes through a two-flop synchroniser. A per-line detector then compares the synchronised level with the value it had one cycle earlier, and evaluates level or edge conditions according to a 3-bit style code. A qualifying condition latches a pending bit in a status register. Software clears a pending bit by writing a one to it. Lines 0 to 12 each own an active-high interrupt output that follows the line's pending bit. Lines 13 to 15 are plain I/O and never become pending.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero except the direction register, which reads 0x0000FFFF. All lines are therefore inputs (`pin_oe` = 0), and `irq` is 0.
- R2: The word registers sit at these byte offsets: 0x00 output data, 0x04 direction, 0x08 input (read-only), 0x0C pending status, 0x10 style for lines 0–7, 0x14 style for lines 8–15, 0x18 clock configuration (32 bits, read/write), and 0x1C debounce select (16 bits, read/write). `rdata` shows the register selected by `addr` one clock edge later. Bits above a register's width read as zero.
- R3: A direction bit n of 1 turns the driver of line n off (`pin_oe[n]`=0). A direction bit of 0 sets `pin_oe[n]`=1. `pin_out` always carries the output data register.
- R4: The input register returns `pin_in` through a two-flop synchroniser. A pin change made before edge E1 first appears in `rdata` after edge E3, and is not there after edge E2.
- R5: Each line has a 3-bit style field. Line k uses bits 3·(k mod 8)+2 : 3·(k mod 8) of the 0x10 register when k<8, and of the 0x14 register otherwise. Bits 31:24 of both style registers read as zero.
- R6: Style 0 (level high) and style 1 (level low) set the pending bit on every cycle the level holds, so a clear cannot take effect while the level persists.
- R7: Style 2 (rising) and style 3 (falling) set the pending bit only on the matching edge. A clear sticks while no new edge arrives. A pin change made before edge E1 raises `irq` after edge E3.
- R8: Style 4 sets the pending bit on both rising and falling edges.
- R9: Styles 5, 6 and 7 never set a pending bit.
- R10: Writing 1 to status bit n clears pending bit n, and writing 0 leaves it unchanged. A detection in the same cycle as a clear wins, and the bit stays set.
- R11: `irq[k]` equals pending bit k for k = 0..12. Status bits 13–15 never set and read as zero, whatever the style and pin activity.
- R12: With the clock configuration register written to zero, lines 14 and 15 work as ordinary outputs and inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 5 | Byte address; the low two bits must be zero for a write to take effect |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for `addr` |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output data value for each line |
| pin_oe | output | 16 | Driver enable for each line, active high |
| irq | output | 13 | Active-high interrupt for lines 0 to 12 |

## Verification
The detectors are exercised with single-line pulses: a held high or low level, a lone rising edge, a lone falling edge, and a full high-then-low cycle. Each pattern is applied under the style that should fire and under one that should not. This separates level persistence from edge-only latching and shows that the reserved codes stay silent. A clear is placed on the exact edge on which a new edge is detected, to show that detection has priority over the clear. A style field in the upper style register, together with activity on lines 13 to 15, confirms the field placement and the interrupt-free upper lines.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned STYLE_W       = 3;
  localparam int unsigned FIELDS_PER_REG = 8;

  typedef enum logic [STYLE_W-1:0] {
    STY_LVL_HI = 3'd0,
    STY_LVL_LO = 3'd1,
    STY_RISE   = 3'd2,
    STY_FALL   = 3'd3,
    STY_ANY    = 3'd4
  } style_e;

  // word index = addr[4:2]
  localparam logic [2:0] W_OUT  = 3'd0;
  localparam logic [2:0] W_DIR  = 3'd1;
  localparam logic [2:0] W_IN   = 3'd2;
  localparam logic [2:0] W_STAT = 3'd3;
  localparam logic [2:0] W_TLO  = 3'd4;
  localparam logic [2:0] W_THI  = 3'd5;
  localparam logic [2:0] W_CLK  = 3'd6;
  localparam logic [2:0] W_DBS  = 3'd7;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect
  import gpio_pkg::*;
(
  input  logic               cur,
  input  logic               prev,
  input  logic [STYLE_W-1:0] style,
  output logic               hit
);
  always_comb begin
    case (style_e'(style))
      STY_LVL_HI: hit = cur;
      STY_LVL_LO: hit = ~cur;
      STY_RISE:   hit = cur & ~prev;
      STY_FALL:   hit = ~cur & prev;
      STY_ANY:    hit = cur ^ prev;
      default:    hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned N_LINES     = 16,
  parameter int unsigned N_IRQ       = 13,
  parameter int unsigned DW          = 32,
  parameter int unsigned AW          = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  input  logic [N_LINES-1:0] pin_in,
  output logic [N_LINES-1:0] pin_out,
  output logic [N_LINES-1:0] pin_oe,
  output logic [N_IRQ-1:0]   irq
);
  localparam int unsigned TYPE_W = STYLE_W * FIELDS_PER_REG;
  localparam logic [N_LINES-1:0] IRQ_MASK = N_LINES'((64'd1 << N_IRQ) - 64'd1);

  logic [N_LINES-1:0] out_q, dir_q, stat_q, dbs_q;
  logic [TYPE_W-1:0]  tlo_q, thi_q;
  logic [DW-1:0]      clk_q;
  logic [N_LINES-1:0] sync_s, prev_q, hit;
  logic [2:0]         wsel;
  logic               wr_ok;
  logic [N_LINES-1:0] clr;

  assign wsel  = addr[AW-1:2];
  assign wr_ok = wr_en && (addr[1:0] == 2'b00);
  assign clr   = (wr_ok && wsel == W_STAT) ? wdata[N_LINES-1:0] : '0;

  gpio_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (sync_s)
  );

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sync_s;
  end

  for (genvar k = 0; k < N_LINES; k++) begin : g_line
    logic [STYLE_W-1:0] sty;
    if (k < FIELDS_PER_REG) begin : g_lo
      assign sty = tlo_q[STYLE_W*k +: STYLE_W];
    end else begin : g_hi
      assign sty = thi_q[STYLE_W*(k-FIELDS_PER_REG) +: STYLE_W];
    end
    gpio_line_detect u_det (
      .cur   (sync_s[k]),
      .prev  (prev_q[k]),
      .style (sty),
      .hit   (hit[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '1;
      tlo_q <= '0;
      thi_q <= '0;
      clk_q <= '0;
      dbs_q <= '0;
    end else if (wr_ok) begin
      case (wsel)
        W_OUT: out_q <= wdata[N_LINES-1:0];
        W_DIR: dir_q <= wdata[N_LINES-1:0];
        W_TLO: tlo_q <= wdata[TYPE_W-1:0];
        W_THI: thi_q <= wdata[TYPE_W-1:0];
        W_CLK: clk_q <= wdata;
        W_DBS: dbs_q <= wdata[N_LINES-1:0];
        default: ;
      endcase
    end
  end

  // detection has priority over a write-one clear
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= ((stat_q & ~clr) | hit) & IRQ_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (wsel)
        W_OUT:  rdata <= DW'(out_q);
        W_DIR:  rdata <= DW'(dir_q);
        W_IN:   rdata <= DW'(sync_s);
        W_STAT: rdata <= DW'(stat_q);
        W_TLO:  rdata <= DW'(tlo_q);
        W_THI:  rdata <= DW'(thi_q);
        W_CLK:  rdata <= clk_q;
        default: rdata <= DW'(dbs_q);
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;
  assign irq     = stat_q[N_IRQ-1:0];
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_pkg::*;
#(
  parameter int unsigned N_LINES = 16,
  parameter int unsigned N_IRQ   = 13,
  parameter int unsigned AW      = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [AW-1:0]      addr,
  input logic [N_LINES-1:0] wdata_lo,
  input logic [7:0]         rdata_top,
  input logic [N_LINES-1:0] pin_oe,
  input logic [N_IRQ-1:0]   irq,
  input logic [N_LINES-1:0] stat_q,
  input logic [N_LINES-1:0] hit
);
  logic was_rst;
  logic wr_dir, wr_stat, rd_type;

  assign wr_dir  = wr_en && addr[1:0] == 2'b00 && addr[AW-1:2] == W_DIR;
  assign wr_stat = wr_en && addr[1:0] == 2'b00 && addr[AW-1:2] == W_STAT;
  assign rd_type = addr[AW-1:2] == W_TLO || addr[AW-1:2] == W_THI;

  always_ff @(posedge clk) begin
    was_rst <= rst;
    if (was_rst && !rst) begin
      p_reset_state_r1: assert (pin_oe == '0 && irq == '0 && stat_q == '0)
        else $error("p_reset_state_r1");
    end
  end

  p_dir_write_r3: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> (pin_oe == ~$past(wdata_lo)));

  p_type_pad_r5: assert property (@(posedge clk) disable iff (rst)
    rd_type |=> (rdata_top == 8'h00));

  p_upper_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    stat_q[N_LINES-1:N_IRQ] == '0);

  for (genvar k = 0; k < N_IRQ; k++) begin : g_k
    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
      (wr_stat && wdata_lo[k] && !hit[k]) |=> !stat_q[k]);
    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
      hit[k] |=> irq[k]);
    p_irq_cause_r11: assert property (@(posedge clk) disable iff (rst)
      $rose(irq[k]) |-> $past(hit[k]));
  end
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.N_LINES(N_LINES), .N_IRQ(N_IRQ), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .addr      (addr),
  .wdata_lo  (wdata[N_LINES-1:0]),
  .rdata_top (rdata[31:24]),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .stat_q    (stat_q),
  .hit       (hit)
);

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [15:0] pin_in;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;
  logic [12:0] irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] tlo = '0;
  logic [31:0] v;
  bit done = 0;

  gpio_irq_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic set_style(input int line, input logic [2:0] code);
    tlo[3*line +: 3] = code;
    wr(5'h10, tlo);
  endtask

  task automatic t_reset;
    chk("R1 pin_oe", 32'(pin_oe), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(5'h04, v); chk("R1 direction", v, 32'h0000FFFF);
    rd(5'h00, v); chk("R1 output", v, 0);
    rd(5'h0C, v); chk("R1 status", v, 0);
    rd(5'h18, v); chk("R1 clock cfg", v, 0);
  endtask

  task automatic t_regs;
    wr(5'h00, 32'hFFFFA5C3); rd(5'h00, v); chk("R2 output rw", v, 32'h0000A5C3);
    wr(5'h18, 32'h12345678); rd(5'h18, v); chk("R2 clock cfg rw", v, 32'h12345678);
    wr(5'h1C, 32'hFFFFFFFF); rd(5'h1C, v); chk("R2 debounce sel rw", v, 32'h0000FFFF);
    wr(5'h14, 32'hFFFFFFFF); rd(5'h14, v); chk("R5 style hi pad", v, 32'h00FFFFFF);
    wr(5'h14, 32'h0);
    wr(5'h08, 32'hFFFF);     rd(5'h08, v); chk("R2 input read-only", v, 0);
    wr(5'h00, 32'h0);
  endtask

  task automatic t_dir;
    wr(5'h00, 32'h0005);
    wr(5'h04, 32'hFFF0);
    chk("R3 oe", 32'(pin_oe), 32'h000F);
    chk("R3 out", 32'(pin_out), 32'h0005);
    wr(5'h04, 32'hFFFF);
    chk("R3 oe off", 32'(pin_oe), 0);
    wr(5'h00, 32'h0);
  endtask

  task automatic t_input;
    @(negedge clk); addr = 5'h08;
    step(2);
    pin_in = 16'hE000;            // before E1
    step(2);                      // after E2
    chk("R4 not yet", rdata, 0);
    step(1);                      // after E3
    chk("R4 sync input", rdata, 32'h0000E000);
    step(2);
    chk("R11 upper lines no irq", 32'(irq), 0);
    rd(5'h0C, v); chk("R11 upper status zero", v, 0);
    pin_in = 16'h0000;
    step(3);
  endtask

  task automatic t_level_high;
    pin_in[0] = 1'b1;
    step(3);
    chk("R6 level high irq", 32'(irq[0]), 1);
    wr(5'h0C, 32'h1);
    chk("R6 clear does not stick", 32'(irq[0]), 1);
    pin_in[0] = 1'b0;
    step(3);
    chk("R6 latched after level gone", 32'(irq[0]), 1);
    wr(5'h0C, 32'h0);
    chk("R10 zero write keeps", 32'(irq[0]), 1);
    wr(5'h0C, 32'h1);
    chk("R10 w1c", 32'(irq[0]), 0);
  endtask

  task automatic t_level_low;
    set_style(1, 3'd1);
    step(1);
    chk("R6 level low irq", 32'(irq[1]), 1);
    pin_in[1] = 1'b1;
    step(3);
    wr(5'h0C, 32'h2);
    step(2);
    chk("R6 level low cleared", 32'(irq[1]), 0);
  endtask

  task automatic t_rising;
    set_style(3, 3'd2);
    pin_in[3] = 1'b1;
    step(2);
    chk("R7 rise not yet", 32'(irq[3]), 0);
    step(1);
    chk("R7 rise irq", 32'(irq[3]), 1);
    wr(5'h0C, 32'h8);
    step(3);
    chk("R7 clear sticks", 32'(irq[3]), 0);
    pin_in[3] = 1'b0;
    step(4);
    chk("R7 fall ignored in rise mode", 32'(irq[3]), 0);
  endtask

  task automatic t_falling;
    set_style(4, 3'd3);
    pin_in[4] = 1'b1;
    step(4);
    chk("R7 rise ignored in fall mode", 32'(irq[4]), 0);
    pin_in[4] = 1'b0;
    step(3);
    chk("R7 fall irq", 32'(irq[4]), 1);
    wr(5'h0C, 32'h10);
    chk("R7 fall cleared", 32'(irq[4]), 0);
  endtask

  task automatic t_both;
    set_style(5, 3'd4);
    pin_in[5] = 1'b1;
    step(3);
    chk("R8 any rise", 32'(irq[5]), 1);
    wr(5'h0C, 32'h20);
    step(2);
    chk("R8 cleared", 32'(irq[5]), 0);
    pin_in[5] = 1'b0;
    step(3);
    chk("R8 any fall", 32'(irq[5]), 1);
    wr(5'h0C, 32'h20);
  endtask

  task automatic t_reserved;
    set_style(6, 3'd5);
    set_style(7, 3'd7);
    pin_in[7:6] = 2'b11;
    step(4);
    pin_in[7:6] = 2'b00;
    step(4);
    chk("R9 reserved irq", 32'(irq[7:6]), 0);
    rd(5'h0C, v); chk("R9 reserved status", v, 0);
  endtask

  task automatic t_race;
    pin_in[3] = 1'b1;             // line 3 is rising mode
    step(4);
    chk("R10 pending before race", 32'(irq[3]), 1);
    pin_in[3] = 1'b0;
    step(4);
    pin_in[3] = 1'b1;             // before E1
    step(2);                      // after E2; detection sampled at E3
    wr_en = 1'b1; addr = 5'h0C; wdata = 32'h8;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 set wins over clear", 32'(irq[3]), 1);
    wr(5'h0C, 32'h8);
    chk("R10 cleared after race", 32'(irq[3]), 0);
  endtask

  task automatic t_typemap;
    wr(5'h14, 32'(3'd2) << 3);    // line 9 rising, field bits 5:3
    rd(5'h14, v); chk("R5 style hi readback", v, 32'h00000010);
    pin_in[9] = 1'b1;
    step(3);
    chk("R5 line 9 via upper style reg", 32'(irq), 32'h0200);
    wr(5'h0C, 32'h200);
    step(2);
    chk("R5 line 9 edge only", 32'(irq[9]), 0);
  endtask

  task automatic t_clkcfg;
    wr(5'h18, 32'h0);
    wr(5'h00, 32'hC000);
    wr(5'h04, 32'h3FFF);
    chk("R12 oe 15:14", 32'(pin_oe[15:14]), 3);
    chk("R12 out 15:14", 32'(pin_out[15:14]), 3);
    wr(5'h04, 32'hFFFF);
    pin_in[15:14] = 2'b10;
    step(3);
    rd(5'h08, v); chk("R12 input 15:14", v & 32'hC000, 32'h8000);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0; pin_in = '0;
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_regs();
    t_dir();
    t_input();
    t_level_high();
    t_level_low();
    t_rising();
    t_falling();
    t_both();
    t_reserved();
    t_race();
    t_typemap();
    t_clkcfg();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule